// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 16-bit successive-approximation converter. A falling edge on the active-low start input begins a conversion. The block then drives a trial word to the capacitive DAC and reads one comparator bit per step, deciding the most significant bit first. When the least significant bit is decided, the block stores the result and drops busy. The result always belongs to the conversion that has just ended, so there is no pipeline latency.

Two mode pins choose one of three speed and power settings. Each setting has its own step length and its own minimum start-to-start period. Results from the fast setting are marked stale when the previous start was too long ago, and the first result after reset in that setting is also marked stale. A format pin selects straight binary or two's complement output. In the low-power setting, a power-up output is released at the end of every conversion.

Top module: `sar_seq`

## Requirements
- R1: A conversion is accepted at a clock edge where the block is idle, `conv_n` is sampled low and was sampled high at the previous edge. `busy` is high from the cycle after that edge.
- R2: `dac_word` starts at 0x8000 and holds the trial word. At the end of each step, the trial bit is kept if `cmp` is 1 (input at or above the trial) and cleared if `cmp` is 0. The next lower bit is then set, and bits below the trial bit stay zero.
- R3: `busy` falls at the edge that decides bit 0. `result` is loaded at that same edge with the code of that conversion and does not change at any other time.
- R4: Mode decode: `warp`=1 with `impulse`=0 selects fast mode. `impulse`=1 with `warp`=0 selects low-power mode. Any other combination, including both pins high, selects normal mode. The mode is captured when a conversion is accepted.
- R5: With the default 100 MHz parameters, a step lasts 10, 12 or 14 cycles (fast, normal, low-power), so `busy` lasts 160, 192 or 224 cycles. A hold-off of 15, 8 or 1 cycles follows, which gives a start-to-start period of at least 175, 200 or 225 cycles.
- R6: If `fmt_bin` is 1 at the final edge, `result` is the straight-binary code. If it is 0, bit 15 is inverted, which gives two's complement.
- R7: `result_stale` is updated only at the final edge. It is set only for a fast-mode conversion whose start came more than the idle limit of cycles after the previous accepted start, or that is the first conversion since reset. Otherwise it is cleared.
- R8: `pwr_up` goes high when a conversion is accepted. It goes low at the final edge of a low-power conversion and stays high after fast and normal conversions. `pwr_up` is high whenever `busy` is high.
- R9: Falling edges of `conv_n` during busy or hold-off are ignored. A `conv_n` that is already low when the block becomes idle does not start a conversion.
- R10: Synchronous active-low reset gives `busy`=0, `dac_word`=0, `result`=0, `result_stale`=1 and `pwr_up`=1.
- R11: The idle-gap count saturates. An idle gap of any length, including one longer than the counter range, still counts as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_n | input | 1 | Active-low convert start |
| warp | input | 1 | Fast-mode select |
| impulse | input | 1 | Low-power-mode select |
| fmt_bin | input | 1 | 1 = straight binary, 0 = two's complement |
| cmp | input | 1 | Comparator decision for the current trial |
| busy | output | 1 | Conversion in progress |
| dac_word | output | 16 | Trial word to the DAC |
| result | output | 16 | Formatted result of the last conversion |
| result_stale | output | 1 | Last result may be inaccurate after a long idle |
| pwr_up | output | 1 | Analog power enable |

## Verification
The assertions check on every cycle that `busy` only rises after `conv_n` was sampled low. They also check that trial bits below the active bit stay clear, that `result` and `result_stale` move only at the final edge, that `pwr_up` covers `busy`, that a hold-off cycle follows every conversion, and that the gap counter stays within its saturation bound. The bench's scenarios are needed for the rest: the exact busy length in each mode, the decoded code values and the format inversion, and the stale flag after the first conversion, after short gaps, after long gaps and after a gap longer than the counter range. Rejected start edges during busy or hold-off and a start input that was already held low can likewise be shown only by driving those sequences.

// File: rtl/sar_pkg.sv
// Shared types and timing helpers for the SAR sequencer.
// Assumes cycle times are given in ns and the clock in whole MHz.
package sar_pkg;
    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_FAST = 2'd1,
        MODE_LOWP = 2'd2
    } sar_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_HOLD = 2'd2
    } sar_state_e;

    // Clock cycles in a full period of the given length.
    function automatic int cyc_of(input int ns, input int mhz);
        return (ns * mhz) / 1000;
    endfunction

    // Cycles per bit step; never below one.
    function automatic int step_of(input int cyc, input int bits);
        return (cyc / bits < 1) ? 1 : cyc / bits;
    endfunction

    // Hold-off cycles after busy; never below one.
    function automatic int hold_of(input int cyc, input int bits);
        int h;
        h = cyc - step_of(cyc, bits) * bits;
        return (h < 1) ? 1 : h;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sar_mode_dec.sv
// Decodes the two mode pins and supplies the step length and hold-off
// for that mode. Assumes the per-mode period parameters fit in CNT_W bits.
module sar_mode_dec
    import sar_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CLK_MHZ   = 100,
    parameter int T_FAST_NS = 1750,
    parameter int T_NORM_NS = 2000,
    parameter int T_LOWP_NS = 2250,
    parameter int CNT_W     = 8
) (
    input  logic             warp,
    input  logic             impulse,
    output sar_mode_e        mode,
    output logic [CNT_W-1:0] step_len,
    output logic [CNT_W-1:0] hold_len
);
    localparam int CYC_FAST  = cyc_of(T_FAST_NS, CLK_MHZ);
    localparam int CYC_NORM  = cyc_of(T_NORM_NS, CLK_MHZ);
    localparam int CYC_LOWP  = cyc_of(T_LOWP_NS, CLK_MHZ);
    localparam int STEP_FAST = step_of(CYC_FAST, DATA_W);
    localparam int STEP_NORM = step_of(CYC_NORM, DATA_W);
    localparam int STEP_LOWP = step_of(CYC_LOWP, DATA_W);
    localparam int HOLD_FAST = hold_of(CYC_FAST, DATA_W);
    localparam int HOLD_NORM = hold_of(CYC_NORM, DATA_W);
    localparam int HOLD_LOWP = hold_of(CYC_LOWP, DATA_W);

    // Pin decode; both pins high falls back to normal mode.
    always_comb begin
        if (warp && !impulse)      mode = MODE_FAST;
        else if (impulse && !warp) mode = MODE_LOWP;
        else                       mode = MODE_NORM;
    end

    // Timing lookup for the decoded mode.
    always_comb begin
        unique case (mode)
            MODE_FAST: begin
                step_len = CNT_W'(STEP_FAST);
                hold_len = CNT_W'(HOLD_FAST);
            end
            MODE_LOWP: begin
                step_len = CNT_W'(STEP_LOWP);
                hold_len = CNT_W'(HOLD_LOWP);
            end
            default: begin
                step_len = CNT_W'(STEP_NORM);
                hold_len = CNT_W'(HOLD_NORM);
            end
        endcase
    end
endmodule

// File: rtl/sar_gap_mon.sv
// Counts cycles since the last accepted start, saturating just above the
// idle limit. Assumes reset means "long gap", so the first start is marked long.
module sar_gap_mon #(
    parameter int GAP_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic long_gap
);
    localparam int GAP_MAX = GAP_CYC + 1;
    localparam int GW      = $clog2(GAP_MAX + 1);

    logic [GW-1:0] gap_cnt;

    // Restart on each accepted start, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                        gap_cnt <= GW'(GAP_MAX);
        else if (accept)                   gap_cnt <= '0;
        else if (gap_cnt != GW'(GAP_MAX))  gap_cnt <= gap_cnt + GW'(1);
    end

    assign long_gap = (gap_cnt > GW'(GAP_CYC));

    a_r11_gap_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GW'(GAP_MAX));
endmodule

// File: rtl/sar_bit_engine.sv
// Successive-approximation state machine: accepts a start when idle,
// walks the trial bit from MSB to LSB with a per-mode step length, then
// waits a hold-off before it can be started again. Assumes step_len >= 1
// and hold_len >= 1.
module sar_bit_engine
    import sar_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  sar_mode_e         mode_in,
    input  logic [CNT_W-1:0]  step_len,
    input  logic [CNT_W-1:0]  hold_len,
    input  logic              cmp,
    output logic              busy,
    output logic              accept,
    output logic              done,
    output logic [DATA_W-1:0] dac_word,
    output logic [DATA_W-1:0] done_word,
    output sar_mode_e         mode_q
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    sar_state_e        st;
    logic [IW-1:0]     bit_idx;
    logic [CNT_W-1:0]  step_cnt;
    logic [CNT_W-1:0]  hold_cnt;
    logic [CNT_W-1:0]  step_q;
    logic [CNT_W-1:0]  hold_q;
    logic [DATA_W-1:0] sar;
    logic [DATA_W-1:0] one_at;
    logic [DATA_W-1:0] next_one;
    logic              step_end;

    assign busy      = (st == ST_CONV);
    assign accept    = (st == ST_IDLE) && start_req;
    assign step_end  = busy && (step_cnt == step_q - CNT_W'(1));
    assign one_at    = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
    assign next_one  = (bit_idx == '0) ? '0 : (one_at >> 1);
    assign done_word = cmp ? sar : (sar & ~one_at);
    assign done      = step_end && (bit_idx == '0);
    assign dac_word  = sar;

    // Sequencing of idle, bit steps and hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bit_idx  <= '0;
            step_cnt <= '0;
            hold_cnt <= '0;
            step_q   <= CNT_W'(1);
            hold_q   <= CNT_W'(1);
            sar      <= '0;
            mode_q   <= MODE_NORM;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start_req) begin
                        st       <= ST_CONV;
                        sar      <= {1'b1, {(DATA_W-1){1'b0}}};
                        bit_idx  <= IW'(DATA_W - 1);
                        step_cnt <= '0;
                        mode_q   <= mode_in;
                        step_q   <= step_len;
                        hold_q   <= hold_len;
                    end
                end
                ST_CONV: begin
                    if (step_end) begin
                        sar      <= done_word | next_one;
                        step_cnt <= '0;
                        if (bit_idx == '0) begin
                            st       <= ST_HOLD;
                            hold_cnt <= '0;
                        end else begin
                            bit_idx <= bit_idx - IW'(1);
                        end
                    end else begin
                        step_cnt <= step_cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (hold_cnt == hold_q - CNT_W'(1)) st <= ST_IDLE;
                    else                                hold_cnt <= hold_cnt + CNT_W'(1);
                end
            endcase
        end
    end

    // R2: untried bits below the active trial bit remain zero.
    a_r2_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((dac_word & (one_at - DATA_W'(1))) == '0));

    // R5: the step counter never runs past its captured length.
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_cnt < step_q));
endmodule

// File: rtl/sar_seq.sv
// Top of the SAR sequencer: detects the start edge, runs the bit engine,
// formats and flags the result, and drives the analog power enable.
// Assumes conv_n is already synchronous to clk.
module sar_seq
    import sar_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CLK_MHZ   = 100,
    parameter int T_FAST_NS = 1750,
    parameter int T_NORM_NS = 2000,
    parameter int T_LOWP_NS = 2250,
    parameter int GAP_US    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_n,
    input  logic              warp,
    input  logic              impulse,
    input  logic              fmt_bin,
    input  logic              cmp,
    output logic              busy,
    output logic [DATA_W-1:0] dac_word,
    output logic [DATA_W-1:0] result,
    output logic              result_stale,
    output logic              pwr_up
);
    localparam int CYC_MAX = imax(cyc_of(T_FAST_NS, CLK_MHZ),
                                  imax(cyc_of(T_NORM_NS, CLK_MHZ),
                                       cyc_of(T_LOWP_NS, CLK_MHZ)));
    localparam int CNT_W   = $clog2(CYC_MAX + 1);
    localparam int GAP_CYC = GAP_US * CLK_MHZ;

    sar_mode_e         pin_mode;
    sar_mode_e         conv_mode;
    logic [CNT_W-1:0]  step_len;
    logic [CNT_W-1:0]  hold_len;
    logic              conv_q;
    logic              start_req;
    logic              eng_accept;
    logic              eng_done;
    logic [DATA_W-1:0] done_word;
    logic              long_gap;
    logic              stale_arm;

    // Previous sample of the start pin, for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_q <= 1'b1;
        else        conv_q <= conv_n;
    end

    assign start_req = conv_q && !conv_n;

    sar_mode_dec #(
        .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ), .T_FAST_NS(T_FAST_NS),
        .T_NORM_NS(T_NORM_NS), .T_LOWP_NS(T_LOWP_NS), .CNT_W(CNT_W)
    ) mode_dec_i (
        .warp(warp), .impulse(impulse), .mode(pin_mode),
        .step_len(step_len), .hold_len(hold_len)
    );

    sar_bit_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode_in(pin_mode),
        .step_len(step_len), .hold_len(hold_len), .cmp(cmp), .busy(busy),
        .accept(eng_accept), .done(eng_done), .dac_word(dac_word),
        .done_word(done_word), .mode_q(conv_mode)
    );

    sar_gap_mon #(.GAP_CYC(GAP_CYC)) gap_i (
        .clk(clk), .rst_n(rst_n), .accept(eng_accept), .long_gap(long_gap)
    );

    // Capture the gap verdict at the start of each conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)          stale_arm <= 1'b1;
        else if (eng_accept) stale_arm <= long_gap;
    end

    // Load the formatted result and its stale flag at the final edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_stale <= 1'b1;
        end else if (eng_done) begin
            result       <= fmt_bin ? done_word
                                    : {~done_word[DATA_W-1], done_word[DATA_W-2:0]};
            result_stale <= (conv_mode == MODE_FAST) && stale_arm;
        end
    end

    // Power enable: raised at start, released after a low-power conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     pwr_up <= 1'b1;
        else if (eng_accept)                            pwr_up <= 1'b1;
        else if (eng_done && conv_mode == MODE_LOWP)    pwr_up <= 1'b0;
    end

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!conv_n));

    a_r3_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(result));

    a_r7_stale_at_end_only: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_done |=> $stable(result_stale));

    a_r8_power_covers_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pwr_up);

    a_r9_holdoff_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !busy);
endmodule

// File: tb/sar_seq_tb.sv
// Bench for sar_seq: a behavioural reference model compared every cycle,
// plus directed scenario checks. Idle limit is shortened to 300 cycles.
module sar_seq_tb_top;
    localparam int GAPL = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_n = 1'b1;
    logic        warp = 1'b0;
    logic        impulse = 1'b0;
    logic        fmt_bin = 1'b1;
    logic [15:0] vin = 16'h0000;
    logic        cmp;
    logic        busy;
    logic [15:0] dac_word;
    logic [15:0] result;
    logic        result_stale;
    logic        pwr_up;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    bit seen_edge = 0;

    always #5 clk = ~clk;

    assign cmp = (vin >= dac_word);

    sar_seq #(.GAP_US(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .warp(warp),
        .impulse(impulse), .fmt_bin(fmt_bin), .cmp(cmp), .busy(busy),
        .dac_word(dac_word), .result(result), .result_stale(result_stale),
        .pwr_up(pwr_up)
    );

    // Reference model state (0 idle, 1 converting, 2 hold-off).
    int          m_state, m_idx, m_step, m_hold, m_stepL, m_holdL, m_mode, m_gap;
    logic [15:0] m_sar, m_result, m_bit;
    logic        m_stale, m_arm, m_pwr, m_prev, m_busy;

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_sar = 0; m_result = 0; m_stale = 1; m_arm = 1;
            m_pwr = 1; m_prev = 1; m_gap = GAPL + 1; m_mode = 0;
            m_idx = 0; m_step = 0; m_hold = 0; m_stepL = 1; m_holdL = 1;
        end else begin
            logic acc;
            acc = (m_state == 0) && m_prev && !conv_n;
            if (acc) begin
                // R4 decode and R5 step / hold-off lengths.
                if (warp && !impulse)      begin m_mode = 1; m_stepL = 10; m_holdL = 15; end
                else if (impulse && !warp) begin m_mode = 2; m_stepL = 14; m_holdL = 1;  end
                else                       begin m_mode = 0; m_stepL = 12; m_holdL = 8;  end
                m_arm = (m_gap > GAPL);
                m_gap = 0;
                m_state = 1; m_idx = 15; m_step = 0; m_sar = 16'h8000; m_pwr = 1;
            end else begin
                m_gap++;
                if (m_state == 1) begin
                    if (m_step == m_stepL - 1) begin
                        m_bit = 16'(1) << m_idx;
                        if (!(vin >= m_sar)) m_sar = m_sar & ~m_bit;
                        m_step = 0;
                        if (m_idx == 0) begin
                            m_result = fmt_bin ? m_sar : (m_sar ^ 16'h8000);
                            m_stale = (m_mode == 1) && m_arm;
                            if (m_mode == 2) m_pwr = 0;
                            m_state = 2; m_hold = 0;
                        end else begin
                            m_idx--;
                            m_sar = m_sar | (16'(1) << m_idx);
                        end
                    end else m_step++;
                end else if (m_state == 2) begin
                    if (m_hold == m_holdL - 1) m_state = 0;
                    else m_hold++;
                end
            end
            m_prev = conv_n;
        end
        m_busy = (m_state == 1);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (seen_edge) begin
            chk(busy == m_busy, "R1", "busy", 32'(busy), 32'(m_busy));
            chk(dac_word == m_sar, "R2", "dac_word", 32'(dac_word), 32'(m_sar));
            chk(result == m_result, "R3", "result", 32'(result), 32'(m_result));
            chk(result_stale == m_stale, "R7", "result_stale", 32'(result_stale), 32'(m_stale));
            chk(pwr_up == m_pwr, "R8", "pwr_up", 32'(pwr_up), 32'(m_pwr));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One conversion with busy length, first trial, result and flag checks.
    task automatic run_conv(input logic w, input logic im, input logic f,
                            input logic [15:0] v, input int exp_busy,
                            input logic exp_stale, input string tag);
        int blen;
        logic [15:0] exp_res;
        @(posedge clk); #1;
        warp = w; impulse = im; fmt_bin = f; vin = v; conv_n = 1'b0;
        @(negedge clk);
        while (!busy) @(negedge clk);
        chk(dac_word == 16'h8000, "R2", {tag, " first trial"}, 32'(dac_word), 32'h8000);
        blen = 0;
        while (busy) begin blen++; @(negedge clk); end
        chk(blen == exp_busy, "R5", {tag, " busy length"}, 32'(blen), 32'(exp_busy));
        exp_res = f ? v : (v ^ 16'h8000);
        chk(result == exp_res, "R6", {tag, " formatted result"}, 32'(result), 32'(exp_res));
        chk(result_stale == exp_stale, "R7", {tag, " stale flag"}, 32'(result_stale), 32'(exp_stale));
        conv_n = 1'b1;
        idle(20);
    endtask

    initial begin
        idle(4);
        // R10: reset values.
        chk(busy == 1'b0, "R10", "reset busy", 32'(busy), 0);
        chk(dac_word == 16'h0, "R10", "reset dac_word", 32'(dac_word), 0);
        chk(result == 16'h0, "R10", "reset result", 32'(result), 0);
        chk(result_stale == 1'b1, "R10", "reset stale", 32'(result_stale), 1);
        chk(pwr_up == 1'b1, "R10", "reset pwr_up", 32'(pwr_up), 1);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(3);

        run_conv(1, 0, 1, 16'hA5C3, 160, 1'b1, "R7 first fast after reset");
        run_conv(1, 0, 1, 16'h1234, 160, 1'b0, "R1 fast short gap");
        run_conv(0, 0, 0, 16'hA5C3, 192, 1'b0, "R6 normal twos complement");
        chk(pwr_up == 1'b1, "R8", "pwr_up after normal", 32'(pwr_up), 1);
        run_conv(0, 1, 0, 16'h7FFF, 224, 1'b0, "R8 low power");
        chk(pwr_up == 1'b0, "R8", "pwr_up after low power", 32'(pwr_up), 0);
        run_conv(1, 1, 1, 16'h0000, 192, 1'b0, "R4 both pins high");
        run_conv(1, 0, 1, 16'hFFFF, 160, 1'b0, "R3 full scale fast");

        // R11: idle past the counter range, then fast: still stale.
        idle(900);
        run_conv(1, 0, 1, 16'h8000, 160, 1'b1, "R11 very long idle");
        idle(400);
        run_conv(0, 0, 1, 16'h0001, 192, 1'b0, "R7 long idle normal");

        // R9: a second falling edge during busy is ignored.
        @(posedge clk); #1; warp = 1; impulse = 0; vin = 16'h3C3C; conv_n = 1'b0;
        idle(40);
        conv_n = 1'b1; idle(2); conv_n = 1'b0;
        while (busy) @(negedge clk);
        // R9: an edge inside the hold-off is ignored too.
        conv_n = 1'b1; idle(2); conv_n = 1'b0;
        idle(30);
        chk(busy == 1'b0, "R9", "edges in busy/hold-off ignored", 32'(busy), 0);
        chk(result == 16'h3C3C, "R9", "result of ignored-edge run", 32'(result), 32'h3C3C);
        // R9: start pin already low while idle does not start.
        idle(20);
        chk(busy == 1'b0, "R9", "held-low start ignored", 32'(busy), 0);
        conv_n = 1'b1;
        idle(5);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule